// File: doc/BRIEF.md
# Two-Phase Delta-Panel Scan Timer

This block produces all digital drive levels for a small active-matrix colour panel whose row and column shift registers are built into the glass. It runs from a single master clock. A position counter walks through each line, and a line counter walks through each frame. Every edge position is a parameter expressed in master-clock counts. The outputs are a complementary column clock pair with its start pulse, a complementary row clock pair with its start pulse, a gate-enable level, a per-line clear pulse, a scan-direction level and a per-line video polarity flag.

The column start pulse is centred on the first rising edge of the first column clock phase, one quarter of a column clock period on either side. On odd lines the whole column scan moves later by half a column clock period, which matches the half-triad offset of the delta pixel rows. The row clock pair completes one period every two lines. The row start pulse is placed a quarter of a row clock period before the frame's first rising edge of the second row phase, and stays high for the same time after that edge.

All control pins are plain levels; the block has no data stream and no handshake. Every output is registered, so an output shows the position counter's value one clock later.

Top module: `panel_scan_timer`

## Requirements
- R1: A synchronous active-high reset puts the block at line 0, position 0 and drives the idle levels: both clock pairs low, both start pulses low, clear low, polarity low, gate-enable high and direction high. The output registered at the k-th clock edge after reset release (k starting at 1) reflects position k-1 of the line/frame walk.
- R2: The clear output `clr_o` is high for the first CLR_W positions of every line and low for the rest of the line.
- R3: The column start `hst_o` is high for HALF_H positions. It rises at position CLR_W+CLR_GAP on even lines and HALF_H positions later on odd lines.
- R4: The first rising edge of `hck1_o` comes HALF_H/2 positions after `hst_o` rises. `hck1_o` then toggles every HALF_H positions for H_STEPS full periods, and `hck2_o` is its complement inside that window. Outside the window both are low, and the two are never high together.
- R5: `vck2_o` is high on even lines and `vck1_o` is high on odd lines, so the row pair is complementary with a period of two lines.
- R6: `vst_o` is high from position LINE_LEN/2 of the last line of a frame through position LINE_LEN/2-1 of the next line 0. It is not raised in line 0 of the first frame after reset.
- R7: With `gate_use_i` high, `en_o` falls EN_DLY positions after each `vck2_o` rise and rises EN_DLY positions after each `vck1_o` rise. With `gate_use_i` low, `en_o` is held high from the next clock edge.
- R8: `rgt_o` follows `scan_right_i` with one clock of delay (high = left-to-right, low = right-to-left).
- R9: The polarity flag `pol_o` is high on odd lines and low on even lines. It therefore inverts at every line start, on the same edge at which `clr_o` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| scan_right_i | input | 1 | Requested column scan direction, 1 = left-to-right |
| gate_use_i | input | 1 | 1 = gate-enable follows row clock edges, 0 = gate-enable held high |
| hck1_o | output | 1 | Column shift clock, first phase |
| hck2_o | output | 1 | Column shift clock, second phase |
| hst_o | output | 1 | Column start pulse |
| vck1_o | output | 1 | Row shift clock, first phase |
| vck2_o | output | 1 | Row shift clock, second phase |
| vst_o | output | 1 | Row start pulse |
| en_o | output | 1 | Gate enable |
| clr_o | output | 1 | Anti-shading clear pulse |
| rgt_o | output | 1 | Column scan direction level |
| pol_o | output | 1 | Video polarity for the current line |

## Verification
A corrupted position counter shows up within one line as a clear pulse of the wrong width, or as a column start that no longer sits a quarter period ahead of the first column clock edge. A wrong line counter, or a line parity that does not change, shows up at the next line boundary: the row pair stops alternating, the polarity flag fails to invert, or the odd-line stagger of the column scan is missing. A frame wrap that fires at the wrong line moves the row start pulse, and the sampled points at the end of the first frame and the start of the second expose it within one frame.

// File: rtl/panel_scan_pkg.sv
package panel_scan_pkg;
  typedef struct packed {
    logic clr;
    logic hst;
    logic hck1;
    logic hck2;
  } col_sig_t;

  typedef struct packed {
    logic vck1;
    logic vck2;
    logic vst;
    logic en;
    logic pol;
  } row_sig_t;
endpackage

// File: rtl/panel_scan_walk.sv
module panel_scan_walk #(
  parameter int LINE_LEN = 72,
  parameter int LINES    = 6,
  localparam int PW = $clog2(LINE_LEN),
  localparam int LW = $clog2(LINES)
) (
  input  logic          clk,
  input  logic          rst,
  output logic [PW-1:0] pos,
  output logic [LW-1:0] line
);
  localparam logic [PW-1:0] POS_END  = PW'(LINE_LEN - 1);
  localparam logic [LW-1:0] LINE_END = LW'(LINES - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      pos  <= '0;
      line <= '0;
    end else if (pos == POS_END) begin
      pos  <= '0;
      line <= (line == LINE_END) ? '0 : line + 1'b1;
    end else begin
      pos <= pos + 1'b1;
    end
  end
endmodule

// File: rtl/panel_col_timing.sv
module panel_col_timing
  import panel_scan_pkg::*;
#(
  parameter int HALF_H  = 4,
  parameter int CLR_W   = 6,
  parameter int CLR_GAP = 3,
  parameter int H_STEPS = 6,
  parameter int PW      = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [PW-1:0] pos,
  input  logic          odd,
  output col_sig_t      col_o
);
  localparam int QTR      = HALF_H / 2;
  localparam int ORG_EVEN = CLR_W + CLR_GAP;
  localparam int ORG_ODD  = ORG_EVEN + HALF_H;
  localparam int SCAN_LEN = 2 * HALF_H * H_STEPS;

  int       p, org, first_edge;
  logic     in_scan;
  col_sig_t nx;

  always_comb begin
    p          = int'(pos);
    org        = odd ? ORG_ODD : ORG_EVEN;
    first_edge = org + QTR;
    in_scan    = (p >= first_edge) && (p < first_edge + SCAN_LEN);
    nx.clr     = p < CLR_W;
    nx.hst     = (p >= org) && (p < org + HALF_H);
    nx.hck1    = in_scan && ((((p - first_edge) / HALF_H) % 2) == 0);
    nx.hck2    = in_scan && ((((p - first_edge) / HALF_H) % 2) != 0);
  end

  always_ff @(posedge clk) begin
    if (rst) col_o <= '0;
    else     col_o <= nx;
  end
endmodule

// File: rtl/panel_row_timing.sv
module panel_row_timing
  import panel_scan_pkg::*;
#(
  parameter int LINE_LEN = 72,
  parameter int LINES    = 6,
  parameter int EN_DLY   = 2,
  parameter int PW       = 7,
  parameter int LW       = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [PW-1:0] pos,
  input  logic [LW-1:0] line,
  input  logic          gate_use,
  output row_sig_t      row_o
);
  localparam int            VHALF    = LINE_LEN / 2;
  localparam logic [LW-1:0] LAST     = LW'(LINES - 1);
  localparam logic [PW-1:0] POS_END  = PW'(LINE_LEN - 1);

  int       p;
  logic     odd;
  logic     primed;
  row_sig_t nx;

  always_comb begin
    p       = int'(pos);
    odd     = line[0];
    nx.vck1 = odd;
    nx.vck2 = !odd;
    nx.vst  = ((line == LAST) && (p >= VHALF)) ||
              ((line == '0) && (p < VHALF) && primed);
    if (!gate_use) nx.en = 1'b1;
    else if (odd)  nx.en = p >= EN_DLY;
    else           nx.en = p < EN_DLY;
    nx.pol  = odd;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      primed <= 1'b0;
      row_o  <= '{vck1: 1'b0, vck2: 1'b0, vst: 1'b0, en: 1'b1, pol: 1'b0};
    end else begin
      if ((line == LAST) && (pos == POS_END)) primed <= 1'b1;
      row_o <= nx;
    end
  end
endmodule

// File: rtl/panel_scan_timer.sv
module panel_scan_timer
  import panel_scan_pkg::*;
#(
  parameter int LINE_LEN = 72,
  parameter int LINES    = 6,
  parameter int HALF_H   = 4,
  parameter int CLR_W    = 6,
  parameter int CLR_GAP  = 3,
  parameter int H_STEPS  = 6,
  parameter int EN_DLY   = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scan_right_i,
  input  logic gate_use_i,
  output logic hck1_o,
  output logic hck2_o,
  output logic hst_o,
  output logic vck1_o,
  output logic vck2_o,
  output logic vst_o,
  output logic en_o,
  output logic clr_o,
  output logic rgt_o,
  output logic pol_o
);
  localparam int PW = $clog2(LINE_LEN);
  localparam int LW = $clog2(LINES);

  logic [PW-1:0] pos;
  logic [LW-1:0] line;
  col_sig_t      col;
  row_sig_t      row;

  panel_scan_walk #(.LINE_LEN(LINE_LEN), .LINES(LINES)) u_walk (
    .clk(clk), .rst(rst), .pos(pos), .line(line)
  );

  panel_col_timing #(
    .HALF_H(HALF_H), .CLR_W(CLR_W), .CLR_GAP(CLR_GAP), .H_STEPS(H_STEPS), .PW(PW)
  ) u_col (
    .clk(clk), .rst(rst), .pos(pos), .odd(line[0]), .col_o(col)
  );

  panel_row_timing #(
    .LINE_LEN(LINE_LEN), .LINES(LINES), .EN_DLY(EN_DLY), .PW(PW), .LW(LW)
  ) u_row (
    .clk(clk), .rst(rst), .pos(pos), .line(line), .gate_use(gate_use_i), .row_o(row)
  );

  always_ff @(posedge clk) begin
    if (rst) rgt_o <= 1'b1;
    else     rgt_o <= scan_right_i;
  end

  assign clr_o  = col.clr;
  assign hst_o  = col.hst;
  assign hck1_o = col.hck1;
  assign hck2_o = col.hck2;
  assign vck1_o = row.vck1;
  assign vck2_o = row.vck2;
  assign vst_o  = row.vst;
  assign en_o   = row.en;
  assign pol_o  = row.pol;
endmodule

// File: rtl/panel_scan_timer_chk.sv
module panel_scan_timer_chk (
  input logic clk,
  input logic rst,
  input logic scan_right_i,
  input logic gate_use_i,
  input logic hck1_o,
  input logic hck2_o,
  input logic hst_o,
  input logic vck1_o,
  input logic vck2_o,
  input logic en_o,
  input logic clr_o,
  input logic rgt_o,
  input logic pol_o
);
  logic seen;
  always_ff @(posedge clk) begin
    if (rst) seen <= 1'b0;
    else     seen <= 1'b1;
  end

  a_r4_phase_excl: assert property (@(posedge clk) disable iff (rst)
    !(hck1_o && hck2_o));

  a_r4_start_before_edge: assert property (@(posedge clk) disable iff (rst)
    $rose(hst_o) |-> (!hck1_o && !hck2_o));

  a_r2_clear_apart: assert property (@(posedge clk) disable iff (rst)
    !(clr_o && hst_o));

  a_r5_row_compl: assert property (@(posedge clk) disable iff (rst)
    seen |-> (vck1_o != vck2_o));

  a_r7_enable_held: assert property (@(posedge clk) disable iff (rst)
    !gate_use_i |=> en_o);

  a_r8_direction: assert property (@(posedge clk) disable iff (rst)
    seen |=> (rgt_o == $past(scan_right_i)));

  a_r9_pol_at_line: assert property (@(posedge clk) disable iff (rst)
    (seen && (pol_o != $past(pol_o))) |-> $rose(clr_o));
endmodule

bind panel_scan_timer panel_scan_timer_chk u_chk (
  .clk(clk), .rst(rst), .scan_right_i(scan_right_i), .gate_use_i(gate_use_i),
  .hck1_o(hck1_o), .hck2_o(hck2_o), .hst_o(hst_o), .vck1_o(vck1_o),
  .vck2_o(vck2_o), .en_o(en_o), .clr_o(clr_o), .rgt_o(rgt_o), .pol_o(pol_o)
);

// File: tb/test_panel_scan_timer.sv
module test_panel_scan_timer;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scan_right_i = 1'b1;
  logic gate_use_i = 1'b1;
  logic hck1_o, hck2_o, hst_o, vck1_o, vck2_o, vst_o, en_o, clr_o, rgt_o, pol_o;

  int n_vec = 0;
  int n_bad = 0;
  int edges = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  panel_scan_timer i_panel_scan_timer (
    .clk(clk), .rst(rst), .scan_right_i(scan_right_i), .gate_use_i(gate_use_i),
    .hck1_o(hck1_o), .hck2_o(hck2_o), .hst_o(hst_o), .vck1_o(vck1_o),
    .vck2_o(vck2_o), .vst_o(vst_o), .en_o(en_o), .clr_o(clr_o),
    .rgt_o(rgt_o), .pol_o(pol_o)
  );

  // Walk position t = line*72 + pos with defaults; bits are
  // {clr, hst, hck1, hck2, vck1, vck2, vst, en, pol}
  localparam int NV = 15;
  localparam int VT [NV] = '{0, 9, 11, 13, 15, 58, 59, 73, 81, 85, 87, 395, 396, 467, 468};
  localparam logic [8:0] VE [NV] = '{
    9'b100001010, 9'b010001000, 9'b011001000, 9'b001001000, 9'b000101000,
    9'b000101000, 9'b000001000, 9'b100010001, 9'b000010011, 9'b010010011,
    9'b011010011, 9'b000110011, 9'b000110111, 9'b001001100, 9'b001001000};

  task automatic chk(string req, string what, logic got, logic exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0b expected %0b", req, what, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    edges = 0;
  endtask

  // output seen after edge t+1 reflects walk position t
  task automatic go_to(int t);
    while (edges < t + 1) begin
      @(posedge clk);
      edges++;
    end
    @(negedge clk);
  endtask

  task automatic check_idle(string tag);
    chk("R1", {tag, " clr"},  clr_o,  1'b0);
    chk("R1", {tag, " hst"},  hst_o,  1'b0);
    chk("R1", {tag, " hck1"}, hck1_o, 1'b0);
    chk("R1", {tag, " hck2"}, hck2_o, 1'b0);
    chk("R1", {tag, " vck1"}, vck1_o, 1'b0);
    chk("R1", {tag, " vck2"}, vck2_o, 1'b0);
    chk("R1", {tag, " vst"},  vst_o,  1'b0);
    chk("R1", {tag, " en"},   en_o,   1'b1);
    chk("R1", {tag, " pol"},  pol_o,  1'b0);
    chk("R1", {tag, " rgt"},  rgt_o,  1'b1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_idle("reset");
    rst = 1'b0;
    edges = 0;

    for (int i = 0; i < NV; i++) begin
      go_to(VT[i]);
      chk("R2", $sformatf("t=%0d clr", VT[i]),  clr_o,  VE[i][8]);
      chk("R3", $sformatf("t=%0d hst", VT[i]),  hst_o,  VE[i][7]);
      chk("R4", $sformatf("t=%0d hck1", VT[i]), hck1_o, VE[i][6]);
      chk("R4", $sformatf("t=%0d hck2", VT[i]), hck2_o, VE[i][5]);
      chk("R5", $sformatf("t=%0d vck1", VT[i]), vck1_o, VE[i][4]);
      chk("R5", $sformatf("t=%0d vck2", VT[i]), vck2_o, VE[i][3]);
      chk("R6", $sformatf("t=%0d vst", VT[i]),  vst_o,  VE[i][2]);
      chk("R7", $sformatf("t=%0d en", VT[i]),   en_o,   VE[i][1]);
      chk("R9", $sformatf("t=%0d pol", VT[i]),  pol_o,  VE[i][0]);
    end

    // R1: reset in mid-run returns to idle levels
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check_idle("mid-run reset");

    // R7: gate enable held high while not in use (t=9 would be low otherwise)
    gate_use_i = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    edges = 0;
    go_to(9);
    chk("R7", "en held with gate unused", en_o, 1'b1);
    go_to(80);
    chk("R7", "en held odd line", en_o, 1'b1);
    gate_use_i = 1'b1;
    go_to(82);
    chk("R7", "en follows gating again", en_o, 1'b1);
    go_to(146);
    chk("R7", "en low on even line after gating", en_o, 1'b0);

    // R8: direction follows input one clock later
    scan_right_i = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R8", "rgt low for right-to-left", rgt_o, 1'b0);
    scan_right_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R8", "rgt high for left-to-right", rgt_o, 1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    done = 1'b1;
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule